// File: doc/BRIEF.md
# Digital Potentiometer Wiper Stepping Sequencer

This block is the host-side driver for a 100-tap digital potentiometer controlled over three wires: an active-low select, a direction level and a step line. A falling edge on the step line moves the wiper by one tap while the part is selected. The level of the step line at the moment select is released decides whether the part commits its position to nonvolatile storage. The block accepts one command at a time, made of a signed step count and a store flag. It turns that command into a sequence of pin transitions that meets every minimum interface time, with each time given as a whole number of system clock cycles.

All minimum times are parameters in clock cycles. Their defaults are derived from a clock-frequency parameter and rounded up. A command moves the wiper by the magnitude of the count, capped at the 99 steps that span the array. The direction follows the sign of the count. After select is released the block keeps waiting: a long wait when the position was stored and a short one when it was not. It then pulses `done` and becomes idle again. A start request that arrives while a command is running is discarded and sets a sticky error flag.

Top module: `wiper_step_driver`

## Requirements
- R1: After reset and whenever `busy` is low, `sel_n` and `step_line` are both high, and `done` and `err_busy` are low after reset.
- R2: A command with a nonzero count produces exactly as many falling edges of `step_line` as the clamped magnitude of `step_count`, and every such edge occurs while `sel_n` is low.
- R3: The magnitude of the signed `step_count` is clamped to TAPS-1 (99 by default). Counts of +127 and -128 therefore both give 99 steps.
- R4: `dir_up` is 1 at every step edge of a command with `step_count` >= 0 and 0 for a negative count. It changes only after select has been low with `step_line` high for T_DIR_HOLD cycles, and it stays stable while `step_line` is low.
- R5: The first falling step edge comes T_DIR_HOLD + max(T_SEL_SETUP, T_DIR_SETUP) cycles after `sel_n` falls, and at every step edge `dir_up` has held its value for at least T_DIR_SETUP cycles.
- R6: Each step low phase lasts T_LOW cycles. Each high phase between two steps lasts max(T_HIGH, T_PERIOD - T_LOW) cycles.
- R7: With `store` = 1, the step line stays high for T_REL_GAP cycles after its last step high phase and `sel_n` rises while `step_line` is high. `sel_n` then stays high for T_STORE_WAIT cycles before `done`. With zero steps, the only high run lasts T_DIR_HOLD + max(T_SEL_SETUP, T_DIR_SETUP) + T_REL_GAP cycles.
- R8: With `store` = 0, the last low phase lasts max(T_LOW, T_REL_GAP) cycles and `sel_n` rises while `step_line` is low. `sel_n` then stays high for T_SKIP_WAIT cycles before `done`.
- R9: A zero count with `store` = 0 causes no pin activity. `busy` stays low and `done` pulses in the cycle after `start`.
- R10: `busy` rises in the cycle after an accepted `start`. It stays high for the sum of all phase lengths and falls in the same cycle as the one-cycle `done` pulse.
- R11: A `start` while `busy` is high is ignored: the running command's steps are unaffected. It sets `err_busy`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled on each rising clock edge |
| step_count | input | CNT_W | Signed step count, with positive values moving up |
| store | input | 1 | 1 commits the final position to storage at release |
| sel_n | output | 1 | Active-low select to the potentiometer |
| dir_up | output | 1 | Direction level, 1 for up |
| step_line | output | 1 | Step line, where a falling edge moves one tap |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when the post-release wait ends |
| err_busy | output | 1 | Sticky flag for a start received while busy |

## Verification
Each pin output is registered and decoded from the next phase, so a pin level shows up one cycle after the edge that chose it. `busy` rises one cycle after the start edge, and `done` arrives exactly the sum of the phase lengths after that. The bench samples on the falling clock edge and measures every run length of the step line while select is low. It compares these lengths, the select-to-first-step delay, the release level, the deselected wait and the total busy count with closed-form values computed from the bench's own phase parameters. A zero no-store command must show `done` at the first falling-edge sample after start, with no select activity.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_REL
    } seq_state_e;

    typedef struct packed {
        logic up;
        logic keep;
    } cmd_t;

    typedef struct packed {
        logic sel_n;
        logic step_lvl;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, step_lvl: 1'b1};

    // Minimum time in ns to clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int hz);
        longint c;
        c = (longint'(ns) * longint'(hz) + 64'sd999_999_999) / 64'sd1_000_000_000;
        if (c < 64'sd1) c = 64'sd1;
        return int'(c);
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wsd_cmd.sv
module wsd_cmd
    import wsd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MAX_STEPS = 99,
    parameter int STEP_W    = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    dec,
    input  logic signed [CNT_W-1:0] count_in,
    input  logic                    keep_in,
    output logic                    in_zero,
    output cmd_t                    cmd,
    output logic [STEP_W-1:0]       left
);
    localparam int MAG_W = CNT_W + 1;

    logic signed [MAG_W-1:0] ext;
    logic        [MAG_W-1:0] mag;
    logic        [STEP_W-1:0] clamped;

    always_comb begin
        ext     = {count_in[CNT_W-1], count_in};
        mag     = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
        clamped = (mag > MAG_W'(MAX_STEPS)) ? STEP_W'(MAX_STEPS) : STEP_W'(mag);
        in_zero = (mag == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '{up: 1'b1, keep: 1'b0};
            left <= '0;
        end else if (load) begin
            cmd.up   <= ~count_in[CNT_W-1];
            cmd.keep <= keep_in;
            left     <= clamped;
        end else if (dec && left != '0) begin
            left <= left - STEP_W'(1);
        end
    end

endmodule

// File: rtl/wsd_timer.sv
module wsd_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // A phase of length N is loaded with N-1 and ends when the count is zero.
    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= len - TW'(1);
        else if (cnt != '0)    cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/wsd_seq.sv
module wsd_seq
    import wsd_pkg::*;
#(
    parameter int TW           = 8,
    parameter int STEP_W       = 7,
    parameter int T_DIR_HOLD   = 1,
    parameter int T_SETUP_W    = 1,
    parameter int T_LOW        = 1,
    parameter int T_HIGH_W     = 1,
    parameter int T_LAST_LOW   = 1,
    parameter int T_REL_GAP    = 1,
    parameter int T_STORE_WAIT = 1,
    parameter int T_SKIP_WAIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_zero,
    input  logic              keep_in,
    input  cmd_t              cmd,
    input  logic [STEP_W-1:0] left,
    input  logic              expired,
    output logic              cmd_load,
    output logic              step_dec,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_len,
    output pins_t             pins,
    output logic              dir_up,
    output logic              busy,
    output logic              done,
    output logic              err
);
    seq_state_e state, nxt;
    pins_t      pins_nxt;
    logic       fin;
    logic [TW-1:0] low_len;

    // The final low phase of a no-store command also covers the release gap.
    always_comb begin
        low_len = (left == STEP_W'(1) && !cmd.keep) ? TW'(T_LAST_LOW) : TW'(T_LOW);
    end

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_len  = '0;
        cmd_load = 1'b0;
        step_dec = 1'b0;
        fin      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (in_zero && !keep_in) begin
                        fin = 1'b1;
                    end else begin
                        nxt      = ST_ARM;
                        tmr_load = 1'b1;
                        tmr_len  = TW'(T_DIR_HOLD);
                        cmd_load = 1'b1;
                    end
                end
            end
            ST_ARM: begin
                if (expired) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(T_SETUP_W);
                end
            end
            ST_SETUP, ST_HIGH: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (left != '0) begin
                        nxt      = ST_LOW;
                        step_dec = 1'b1;
                        tmr_len  = low_len;
                    end else begin
                        nxt     = ST_TAIL;
                        tmr_len = TW'(T_REL_GAP);
                    end
                end
            end
            ST_LOW: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (left == '0 && !cmd.keep) begin
                        nxt     = ST_REL;
                        tmr_len = TW'(T_SKIP_WAIT);
                    end else begin
                        nxt     = ST_HIGH;
                        tmr_len = TW'(T_HIGH_W);
                    end
                end
            end
            ST_TAIL: begin
                if (expired) begin
                    nxt      = ST_REL;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(T_STORE_WAIT);
                end
            end
            ST_REL: begin
                if (expired) begin
                    nxt = ST_IDLE;
                    fin = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pins_nxt.sel_n    = (nxt == ST_IDLE) || (nxt == ST_REL);
        pins_nxt.step_lvl = !((nxt == ST_LOW) || (nxt == ST_REL && !cmd.keep));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pins   <= PINS_IDLE;
            dir_up <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            state <= nxt;
            pins  <= pins_nxt;
            busy  <= (nxt != ST_IDLE);
            done  <= fin;
            if (start && state != ST_IDLE) err <= 1'b1;
            if (state == ST_ARM && expired) dir_up <= cmd.up;
        end
    end

endmodule

// File: rtl/wiper_step_driver.sv
module wiper_step_driver
    import wsd_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int CNT_W        = 8,
    parameter int TAPS         = 100,
    parameter int T_DIR_HOLD   = ns_to_cyc(100, CLK_HZ),
    parameter int T_SEL_SETUP  = ns_to_cyc(100, CLK_HZ),
    parameter int T_DIR_SETUP  = ns_to_cyc(2_900, CLK_HZ),
    parameter int T_LOW        = ns_to_cyc(1_000, CLK_HZ),
    parameter int T_HIGH       = ns_to_cyc(1_000, CLK_HZ),
    parameter int T_PERIOD     = ns_to_cyc(2_000, CLK_HZ),
    parameter int T_REL_GAP    = ns_to_cyc(1_000, CLK_HZ),
    parameter int T_STORE_WAIT = ns_to_cyc(20_000_000, CLK_HZ),
    parameter int T_SKIP_WAIT  = ns_to_cyc(100, CLK_HZ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [CNT_W-1:0] step_count,
    input  logic                    store,
    output logic                    sel_n,
    output logic                    dir_up,
    output logic                    step_line,
    output logic                    busy,
    output logic                    done,
    output logic                    err_busy
);
    localparam int MAX_STEPS  = TAPS - 1;
    localparam int STEP_W     = $clog2(TAPS);
    localparam int T_SETUP_W  = max_i(T_SEL_SETUP, T_DIR_SETUP);
    localparam int T_HIGH_W   = max_i(T_HIGH, T_PERIOD - T_LOW);
    localparam int T_LAST_LOW = max_i(T_LOW, T_REL_GAP);
    localparam int T_MAX      = max_i(max_i(max_i(T_DIR_HOLD, T_SETUP_W), max_i(T_HIGH_W, T_LAST_LOW)),
                                      max_i(T_STORE_WAIT, T_SKIP_WAIT));
    localparam int TW         = $clog2(T_MAX + 1);

    logic              cmd_load, step_dec, in_zero, tmr_load, expired;
    logic [TW-1:0]     tmr_len;
    logic [STEP_W-1:0] left;
    cmd_t              cmd;
    pins_t             pins;

    wsd_cmd #(
        .CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)
    ) u_cmd (
        .clk(clk), .rst(rst), .load(cmd_load), .dec(step_dec),
        .count_in(step_count), .keep_in(store),
        .in_zero(in_zero), .cmd(cmd), .left(left)
    );

    wsd_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(expired)
    );

    wsd_seq #(
        .TW(TW), .STEP_W(STEP_W), .T_DIR_HOLD(T_DIR_HOLD), .T_SETUP_W(T_SETUP_W),
        .T_LOW(T_LOW), .T_HIGH_W(T_HIGH_W), .T_LAST_LOW(T_LAST_LOW),
        .T_REL_GAP(T_REL_GAP), .T_STORE_WAIT(T_STORE_WAIT), .T_SKIP_WAIT(T_SKIP_WAIT)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .in_zero(in_zero), .keep_in(store),
        .cmd(cmd), .left(left), .expired(expired),
        .cmd_load(cmd_load), .step_dec(step_dec), .tmr_load(tmr_load), .tmr_len(tmr_len),
        .pins(pins), .dir_up(dir_up), .busy(busy), .done(done), .err(err_busy)
    );

    assign sel_n     = pins.sel_n;
    assign step_line = pins.step_lvl;

endmodule

// File: rtl/wsd_checker.sv
module wsd_checker #(
    parameter int T_DIR_HOLD = 1,
    parameter int T_LOW      = 1
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sel_n,
    input logic dir_up,
    input logic step_line,
    input logic busy,
    input logic done,
    input logic err_busy
);
    int unsigned hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            if (!step_line)                     hi_run <= 0;
            else if (hi_run < T_DIR_HOLD)       hi_run <= hi_run + 1;
            if (step_line)                      lo_run <= 0;
            else if (lo_run < T_LOW)            lo_run <= lo_run + 1;
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sel_n && step_line));                               // R1
    AST_FALL_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $fell(step_line) |-> !sel_n);                                  // R2
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(dir_up) |-> (hi_run >= T_DIR_HOLD));                  // R4
    AST_DIR_STEADY_LOW: assert property (@(posedge clk) disable iff (rst)
        !step_line |-> $stable(dir_up));                               // R4
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_line) && !sel_n) |-> (lo_run >= T_LOW));           // R6
    AST_RELEASE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_n) |-> $stable(step_line));                          // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                               // R10
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> err_busy);                                 // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_busy |=> err_busy);                                        // R11

endmodule

bind wiper_step_driver wsd_checker #(
    .T_DIR_HOLD(T_DIR_HOLD), .T_LOW(T_LOW)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .sel_n(sel_n), .dir_up(dir_up),
    .step_line(step_line), .busy(busy), .done(done), .err_busy(err_busy)
);

// File: tb/sim_wiper_step_driver.sv
module sim_wiper_step_driver;
    localparam int DH = 2, SEL = 3, DSU = 5, LOWC = 4, HIGHC = 3, PER = 9;
    localparam int GAP = 6, TST = 40, TSK = 3;
    localparam int S  = (SEL > DSU) ? SEL : DSU;
    localparam int HW = (HIGHC > PER - LOWC) ? HIGHC : PER - LOWC;
    localparam int LL = (LOWC > GAP) ? LOWC : GAP;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, store = 1'b0;
    logic signed [7:0] step_count = '0;
    logic sel_n, dir_up, step_line, busy, done, err_busy;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wiper_step_driver #(
        .T_DIR_HOLD(DH), .T_SEL_SETUP(SEL), .T_DIR_SETUP(DSU), .T_LOW(LOWC),
        .T_HIGH(HIGHC), .T_PERIOD(PER), .T_REL_GAP(GAP),
        .T_STORE_WAIT(TST), .T_SKIP_WAIT(TSK)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .step_count(step_count), .store(store),
        .sel_n(sel_n), .dir_up(dir_up), .step_line(step_line),
        .busy(busy), .done(done), .err_busy(err_busy)
    );

    // Monitor state, sampled on the falling clock edge.
    logic p_sel = 1'b1, p_stp = 1'b1, p_dir = 1'b1;
    int busy_len, falls, first_delay, lo_bad, hi_bad, dir_bad, dsu_bad, dh_bad;
    int run_cnt, sel_cnt, rel_wait, tail_len, dir_age, sel_seen;
    bit rel_level, got_done, done_busy, exp_dir;

    task automatic mon_clear();
        busy_len = 0; falls = 0; first_delay = -1; lo_bad = 0; hi_bad = 0;
        dir_bad = 0; dsu_bad = 0; dh_bad = 0; run_cnt = 0; sel_cnt = 0;
        rel_wait = 0; tail_len = -1; sel_seen = 0; rel_level = 1'b0;
        got_done = 0; done_busy = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_len++;
            if (done) begin got_done = 1; if (busy) done_busy = 1; end
            if (dir_up != p_dir) dir_age = 0;
            if (!sel_n) begin
                sel_seen = 1;
                if (p_sel) begin sel_cnt = 0; run_cnt = 0; end
                if (dir_up != p_dir && sel_cnt < DH) dh_bad++;
                if (!p_sel && p_stp && !step_line) begin
                    falls++;
                    if (dir_up != exp_dir) dir_bad++;
                    if (dir_age < DSU) dsu_bad++;
                    if (falls == 1) first_delay = sel_cnt;
                    else if (run_cnt != HW) hi_bad++;
                    run_cnt = 0;
                end else if (!p_sel && !p_stp && step_line) begin
                    if (run_cnt != LOWC) lo_bad++;
                    run_cnt = 0;
                end
                run_cnt++;
                sel_cnt++;
            end else if (!p_sel) begin
                rel_level = step_line;
                tail_len = run_cnt;
            end
            if (sel_n && busy) rel_wait++;
            dir_age++;
            p_sel = sel_n; p_stp = step_line; p_dir = dir_up;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mag(input int c);
        int m;
        m = (c < 0) ? -c : c;
        return (m > 99) ? 99 : m;
    endfunction

    function automatic int exp_busy(input int m, input bit keep);
        if (m == 0) return keep ? DH + S + GAP + TST : 0;
        if (keep) return DH + S + m * (LOWC + HW) + GAP + TST;
        return DH + S + (m - 1) * (LOWC + HW) + LL + TSK;
    endfunction

    task automatic run_cmd(input int c, input bit keep, input bit inject);
        int m, guard;
        m = exp_mag(c);
        @(negedge clk);
        mon_clear();
        exp_dir = (c >= 0);
        step_count = 8'(c);
        store = keep;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!got_done && guard < 5000) begin
            if (inject && guard == 8) begin
                start = 1'b1; step_count = -8'sd7; store = ~keep;
            end else if (inject && guard == 9) begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        check(got_done == 1, "R10 done seen", int'(got_done), 1);
        check(done_busy == 0, "R10 done with busy low", done_busy, 0);
        check(busy_len == exp_busy(m, keep), "R10 busy length", busy_len, exp_busy(m, keep));
        check(falls == m, (c > 99 || c < -99) ? "R3 clamped steps" : "R2 step count", falls, m);
        check(dir_bad == 0, "R4 direction polarity", dir_bad, 0);
        check(dh_bad == 0, "R4 direction hold", dh_bad, 0);
        check(dsu_bad == 0, "R5 direction setup", dsu_bad, 0);
        check(lo_bad == 0 && hi_bad == 0, "R6 phase widths", lo_bad + hi_bad, 0);
        if (m == 0 && !keep) begin
            check(sel_seen == 0, "R9 no select activity", sel_seen, 0);
        end else begin
            if (m > 0) check(first_delay == DH + S, "R5 select to first step", first_delay, DH + S);
            if (keep) begin
                check(rel_level == 1'b1, "R7 release level high", int'(rel_level), 1);
                check(tail_len == ((m == 0) ? DH + S + GAP : HW + GAP), "R7 tail run",
                      tail_len, (m == 0) ? DH + S + GAP : HW + GAP);
                check(rel_wait == TST, "R7 store wait", rel_wait, TST);
            end else begin
                check(rel_level == 1'b0, "R8 release level low", int'(rel_level), 0);
                check(tail_len == LL, "R8 final low run", tail_len, LL);
                check(rel_wait == TSK, "R8 skip wait", rel_wait, TSK);
            end
        end
        check(sel_n && step_line, "R1 idle pins", {30'd0, sel_n, step_line}, 3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(sel_n == 1 && step_line == 1, "R1 reset pins", {30'd0, sel_n, step_line}, 3);
        check(busy == 0 && done == 0, "R1 reset busy/done", {30'd0, busy, done}, 0);
        check(err_busy == 0, "R1 reset error", int'(err_busy), 0);
        run_cmd(5, 1, 0);
        run_cmd(-3, 0, 0);
        run_cmd(0, 0, 0);
        run_cmd(0, 1, 0);
        run_cmd(1, 0, 0);
        run_cmd(-1, 1, 0);
        run_cmd(127, 1, 0);
        run_cmd(-128, 0, 0);
        run_cmd(99, 0, 0);
        run_cmd(-100, 1, 0);
        run_cmd(2, 0, 0);
        check(err_busy == 0, "R11 no error yet", int'(err_busy), 0);
        run_cmd(12, 0, 1);
        check(err_busy == 1, "R11 error set", int'(err_busy), 1);
        for (int i = 0; i < 30; i++) begin
            int c;
            c = $signed(8'($urandom_range(0, 255)));
            run_cmd(c, 1'($urandom_range(0, 1)), 0);
        end
        check(err_busy == 1, "R11 error sticky", int'(err_busy), 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule